// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit

This block is the multiply and divide engine of a small 8/16-bit controller datapath. It takes unsigned byte or word operands and produces either a product or a quotient and remainder. A one-cycle start request latches the operation, the operand size, the timing mode and both operands. The unit then runs for a fixed number of states and raises a one-cycle done pulse on the last of them. The surrounding pipeline can therefore account for the operation as a known, constant cost.

Results are split into an A-side word and a B-side word, in the way an accumulator/B-register pair is used on classic 8-bit controllers. A multiply puts the low half of the product on the A side and the high half on the B side. A divide puts the quotient on the A side and the remainder on the B side. Two flags come with the result. The overflow flag reports a nonzero high product half, or a zero divisor. The carry flag is always cleared.

Latency depends on the operation and the operand size. A mode input selects native timing, or a compatibility timing that adds one state to every register-to-register form. A form input tells the unit whether a byte operation is the register-to-register form or the accumulator-by-B form. Word operations are always register-to-register.

The FSM has three states:
- `S_IDLE`: waiting. The transition IDLE→CALC happens on start.
- `S_CALC`: iterative arithmetic, two multiplier bits or one quotient bit per state. The transition CALC→ALIGN happens after the last step.
- `S_ALIGN`: padding states up to the selected latency. The transition ALIGN→IDLE happens on the done state.

Top module: `muldiv_seq`

## Requirements
- R1: Byte multiply (`size_word_i`=0, `op_div_i`=0) uses only `opa_i[7:0]` and `opb_i[7:0]`. On the done cycle, `res_a_o` = {8'h00, product[7:0]} and `res_b_o` = {8'h00, product[15:8]}.
- R2: Word multiply (`size_word_i`=1) gives `res_a_o` = product[15:0] and `res_b_o` = product[31:16] on the done cycle.
- R3: Divide (`op_div_i`=1) with a nonzero divisor gives `res_a_o` = quotient and `res_b_o` = remainder on the done cycle. Byte divide uses only the low operand bytes and zero-extends the results.
- R4: In native mode (`compat_i`=0), `done_o` rises in the L-th cycle after the clock edge that accepts start. L is 5 for a byte multiply, 10 for a byte divide, 11 for a word multiply and 20 for a word divide.
- R5: In compatibility mode (`compat_i`=1), register-to-register forms take one extra state. That gives 6 and 11 for byte multiply and divide with `form_reg_i`=1, and 12 and 21 for word multiply and divide whatever the value of `form_reg_i`. Byte forms with `form_reg_i`=0 keep 5 and 10.
- R6: A divide by zero sets `ovf_o` on the done cycle. While the unit is idle and no start is applied, `res_a_o` and `res_b_o` do not change.
- R7: On the done cycle of a multiply, `ovf_o` is 1 exactly when the high half of the product is nonzero. On the done cycle of a divide by a nonzero divisor, `ovf_o` is 0.
- R8: `cy_o` is 0 on the done cycle of every operation.
- R9: A start request while `busy_o` is high is ignored. Operand and control inputs that change after the accepting edge have no effect on the result or on the latency.
- R10: `busy_o` is high from the first cycle after the accepting edge through the done cycle. `done_o` is a single-cycle pulse, and `busy_o` is low in the following cycle.
- R11: After reset, `busy_o`, `done_o`, `res_a_o` and `res_b_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, accepted only when idle |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| size_word_i | input | 1 | 0 = byte operands, 1 = word operands |
| form_reg_i | input | 1 | 1 = register-to-register byte form, 0 = accumulator-by-B form |
| compat_i | input | 1 | 1 = compatibility timing, 0 = native timing |
| opa_i | input | W | Multiplicand or dividend |
| opb_i | input | W | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | High on the last state of the operation |
| res_a_o | output | W | Low product half, or quotient |
| res_b_o | output | W | High product half, or remainder |
| ovf_o | output | 1 | Nonzero product high half, or zero divisor |
| cy_o | output | 1 | Carry, always cleared |

## Verification
The hardest situation to reach from the ports is a second start request, together with changed operands, arriving in the middle of an operation. Only that case shows that operands were latched and that the state counter was not reloaded. The bench injects such a request, with inverted operands, in the second state of selected operations during the sweep. It then checks that both the result and the done cycle still match the original request. The byte sweeps cover the full operand range, including a zero divisor and 255×255. Every combination of operation, size, form and mode is timed against its own expected state count.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CALC  = 2'd1,
        S_ALIGN = 2'd2
    } md_state_e;

    typedef struct packed {
        logic is_div;
        logic is_word;
    } md_op_t;

endpackage

// File: rtl/muldiv_lat.sv
module muldiv_lat #(
    parameter int unsigned LAT_MUL_B    = 5,
    parameter int unsigned LAT_MUL_W    = 11,
    parameter int unsigned LAT_DIV_B    = 10,
    parameter int unsigned LAT_DIV_W    = 20,
    parameter int unsigned COMPAT_EXTRA = 1,
    parameter int          CW           = 5
) (
    input  logic          is_div,
    input  logic          is_word,
    input  logic          reg_form,
    input  logic          compat,
    output logic [CW-1:0] lat_m1
);
    int unsigned base;
    logic        slow;

    // Total state count minus one: the launch state is counted by the load.
    always_comb begin
        if (is_div) base = is_word ? LAT_DIV_W : LAT_DIV_B;
        else        base = is_word ? LAT_MUL_W : LAT_MUL_B;
        slow   = compat && (is_word || reg_form);
        lat_m1 = CW'(base + (slow ? COMPAT_EXTRA : 0) - 1);
    end
endmodule

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [1:0]     dig_i,
    output logic [2*W-1:0] acc_o
);
    logic [2*W-1:0] m1;
    logic [2*W-1:0] part;

    // Radix-4 shift-add: the accumulator moves up two places, then the selected multiple is added.
    always_comb begin
        m1 = {{W{1'b0}}, mcand_i};
        unique case (dig_i)
            2'd0: part = '0;
            2'd1: part = m1;
            2'd2: part = m1 << 1;
            2'd3: part = m1 + (m1 << 1);
            default: part = '0;
        endcase
        acc_o = (acc_i << 2) + part;
    end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] trial;
    logic       ge;

    // Restoring step: bring in the next dividend bit, subtract if it fits.
    always_comb begin
        trial = {rem_i, quo_i[W-1]};
        ge    = trial >= {1'b0, dvs_i};
        rem_o = ge ? W'(trial - {1'b0, dvs_i}) : trial[W-1:0];
        quo_o = {quo_i[W-2:0], ge};
    end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int          W            = 16,
    parameter int unsigned LAT_MUL_B    = 5,
    parameter int unsigned LAT_MUL_W    = 11,
    parameter int unsigned LAT_DIV_B    = 10,
    parameter int unsigned LAT_DIV_W    = 20,
    parameter int unsigned COMPAT_EXTRA = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         op_div_i,
    input  logic         size_word_i,
    input  logic         form_reg_i,
    input  logic         compat_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] res_a_o,
    output logic [W-1:0] res_b_o,
    output logic         ovf_o,
    output logic         cy_o
);
    localparam int HW      = W / 2;
    localparam int LAT_MAX = int'(LAT_DIV_W + COMPAT_EXTRA);
    localparam int CW      = $clog2(LAT_MAX + 1);
    localparam int SW      = $clog2(W + 1);
    localparam logic [SW-1:0] STEPS_MB = SW'(HW / 2);
    localparam logic [SW-1:0] STEPS_MW = SW'(W / 2);
    localparam logic [SW-1:0] STEPS_DB = SW'(HW);
    localparam logic [SW-1:0] STEPS_DW = SW'(W);

    md_state_e      state, nxt;
    md_op_t         op;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  lat_m1;
    logic [SW-1:0]  steps;
    logic [W-1:0]   mcand, mplier, quo, rem, dvs;
    logic [2*W-1:0] acc;
    logic [2*W-1:0] acc_nx;
    logic [W-1:0]   quo_nx, rem_nx;
    logic           accept;

    assign accept = (state == S_IDLE) && start_i;

    muldiv_lat #(
        .LAT_MUL_B(LAT_MUL_B), .LAT_MUL_W(LAT_MUL_W),
        .LAT_DIV_B(LAT_DIV_B), .LAT_DIV_W(LAT_DIV_W),
        .COMPAT_EXTRA(COMPAT_EXTRA), .CW(CW)
    ) u_lat (
        .is_div  (op_div_i),
        .is_word (size_word_i),
        .reg_form(form_reg_i),
        .compat  (compat_i),
        .lat_m1  (lat_m1)
    );

    muldiv_mul_step #(.W(W)) u_mul (
        .acc_i  (acc),
        .mcand_i(mcand),
        .dig_i  (mplier[W-1:W-2]),
        .acc_o  (acc_nx)
    );

    muldiv_div_step #(.W(W)) u_div (
        .rem_i(rem),
        .quo_i(quo),
        .dvs_i(dvs),
        .rem_o(rem_nx),
        .quo_o(quo_nx)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start_i)            nxt = S_CALC;
            S_CALC:  if (steps == SW'(1))    nxt = S_ALIGN;
            S_ALIGN: if (cnt == '0)          nxt = S_IDLE;
            default:                         nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Datapath and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op     <= '0;
            cnt    <= '0;
            steps  <= '0;
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            quo    <= '0;
            rem    <= '0;
            dvs    <= '0;
        end else if (accept) begin
            op.is_div  <= op_div_i;
            op.is_word <= size_word_i;
            cnt        <= lat_m1;
            acc        <= '0;
            rem        <= '0;
            if (size_word_i) begin
                mcand  <= opa_i;
                mplier <= opb_i;
                quo    <= opa_i;
                dvs    <= opb_i;
                steps  <= op_div_i ? STEPS_DW : STEPS_MW;
            end else begin
                // Byte operands sit at the top so the shifting steps consume them first.
                mcand  <= {{HW{1'b0}}, opa_i[HW-1:0]};
                mplier <= {opb_i[HW-1:0], {HW{1'b0}}};
                quo    <= {opa_i[HW-1:0], {HW{1'b0}}};
                dvs    <= {{HW{1'b0}}, opb_i[HW-1:0]};
                steps  <= op_div_i ? STEPS_DB : STEPS_MB;
            end
        end else begin
            unique case (state)
                S_CALC: begin
                    steps <= steps - SW'(1);
                    cnt   <= cnt - CW'(1);
                    if (op.is_div) begin
                        quo <= quo_nx;
                        rem <= rem_nx;
                    end else begin
                        acc    <= acc_nx;
                        mplier <= mplier << 2;
                    end
                end
                S_ALIGN: if (cnt != '0) cnt <= cnt - CW'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o = (state != S_IDLE);
        done_o = (state == S_ALIGN) && (cnt == '0);
        cy_o   = 1'b0;
        if (op.is_div) begin
            res_a_o = quo;
            res_b_o = rem;
            ovf_o   = (dvs == '0);
        end else if (op.is_word) begin
            res_a_o = acc[W-1:0];
            res_b_o = acc[2*W-1:W];
            ovf_o   = (acc[2*W-1:W] != '0);
        end else begin
            res_a_o = {{HW{1'b0}}, acc[HW-1:0]};
            res_b_o = {{HW{1'b0}}, acc[W-1:HW]};
            ovf_o   = (acc[W-1:HW] != '0);
        end
    end
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
    parameter int          W            = 16,
    parameter int unsigned LAT_MUL_B    = 5,
    parameter int unsigned LAT_MUL_W    = 11,
    parameter int unsigned LAT_DIV_B    = 10,
    parameter int unsigned LAT_DIV_W    = 20,
    parameter int unsigned COMPAT_EXTRA = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         op_div_i,
    input logic         size_word_i,
    input logic         form_reg_i,
    input logic         compat_i,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] res_a_o,
    input logic [W-1:0] res_b_o,
    input logic         ovf_o
);
    localparam int HW = W / 2;

    logic           c_div, c_word, c_form, c_compat;
    logic [W-1:0]   c_a, c_b;
    logic [7:0]     cyc;
    logic [7:0]     exp_lat;
    logic [2*W-1:0] prod_w;
    logic [W-1:0]   prod_b;
    logic           dvs_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_div <= 1'b0; c_word <= 1'b0; c_form <= 1'b0; c_compat <= 1'b0;
            c_a <= '0; c_b <= '0; cyc <= '0;
        end else if (start_i && !busy_o) begin
            c_div <= op_div_i; c_word <= size_word_i;
            c_form <= form_reg_i; c_compat <= compat_i;
            c_a <= opa_i; c_b <= opb_i;
            cyc <= 8'd1;
        end else if (busy_o) begin
            cyc <= cyc + 8'd1;
        end
    end

    always_comb begin
        if (c_div) exp_lat = c_word ? 8'(LAT_DIV_W) : 8'(LAT_DIV_B);
        else       exp_lat = c_word ? 8'(LAT_MUL_W) : 8'(LAT_MUL_B);
        if (c_compat && (c_word || c_form)) exp_lat = exp_lat + 8'(COMPAT_EXTRA);
        prod_w   = {{W{1'b0}}, c_a} * {{W{1'b0}}, c_b};
        prod_b   = {{HW{1'b0}}, c_a[HW-1:0]} * {{HW{1'b0}}, c_b[HW-1:0]};
        dvs_zero = c_word ? (c_b == '0) : (c_b[HW-1:0] == '0);
    end

    assert_latency_native_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !c_compat) |-> (cyc == exp_lat));
    assert_latency_compat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_compat) |-> (cyc == exp_lat));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
    assert_mul_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !c_div && !c_word) |-> ({res_b_o[HW-1:0], res_a_o[HW-1:0]} == prod_b));
    assert_mul_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !c_div && c_word) |-> ({res_b_o, res_a_o} == prod_w));
    assert_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_div && c_word && !dvs_zero) |-> (res_a_o == c_a / c_b && res_b_o == c_a % c_b));
    assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_div && dvs_zero) |-> ovf_o);
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(res_a_o) && $stable(res_b_o)));
    assert_mul_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !c_div) |-> (ovf_o == (c_word ? (prod_w[2*W-1:W] != '0) : (prod_b[W-1:HW] != '0))));
endmodule

bind muldiv_seq muldiv_seq_chk #(
    .W(W), .LAT_MUL_B(LAT_MUL_B), .LAT_MUL_W(LAT_MUL_W),
    .LAT_DIV_B(LAT_DIV_B), .LAT_DIV_W(LAT_DIV_W), .COMPAT_EXTRA(COMPAT_EXTRA)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
    .size_word_i(size_word_i), .form_reg_i(form_reg_i), .compat_i(compat_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .res_a_o(res_a_o), .res_b_o(res_b_o), .ovf_o(ovf_o)
);

// File: tb/muldiv_seq_tb.sv
module muldiv_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_div_i = 1'b0;
    logic        size_word_i = 1'b0;
    logic        form_reg_i = 1'b0;
    logic        compat_i = 1'b0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic        busy_o, done_o, ovf_o, cy_o;
    logic [15:0] res_a_o, res_b_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
        .size_word_i(size_word_i), .form_reg_i(form_reg_i), .compat_i(compat_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .res_a_o(res_a_o), .res_b_o(res_b_o), .ovf_o(ovf_o), .cy_o(cy_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic d, input logic w, input logic f, input logic c,
                          input logic [15:0] a, input logic [15:0] b, input bit inject);
        int          n;
        int          lat;
        logic [31:0] prod;
        logic [15:0] ea, eb, ma, mb, ha, hb;
        logic        eo, zero;
        lat = d ? (w ? 20 : 10) : (w ? 11 : 5);
        if (c && (w || f)) lat++;
        ma = w ? a : {8'h00, a[7:0]};
        mb = w ? b : {8'h00, b[7:0]};
        zero = (mb == 16'h0);
        prod = {16'h0, ma} * {16'h0, mb};
        if (d) begin
            ea = zero ? 16'h0 : ma / mb;
            eb = zero ? 16'h0 : ma % mb;
            eo = zero;
        end else if (w) begin
            ea = prod[15:0]; eb = prod[31:16]; eo = (prod[31:16] != 0);
        end else begin
            ea = {8'h00, prod[7:0]}; eb = {8'h00, prod[15:8]}; eo = (prod[15:8] != 0);
        end
        @(negedge clk);
        op_div_i = d; size_word_i = w; form_reg_i = f; compat_i = c;
        opa_i = a; opb_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        chk(busy_o == 1'b1, "R10 busy after accept", 32'(busy_o), 32'd1);
        while (!done_o && n < 64) begin
            if (inject && n == 2) begin
                // R9: restart with altered inputs mid-operation
                start_i = 1'b1; opa_i = ~a; opb_i = a ^ b ^ 16'h5a5a;
                op_div_i = ~d; size_word_i = ~w; compat_i = ~c;
            end
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        if (c) chk(n == lat, "R5 compat latency", 32'(n), 32'(lat));
        else   chk(n == lat, "R4 native latency", 32'(n), 32'(lat));
        if (d && zero) begin
            chk(ovf_o == 1'b1, "R6 div zero ovf", 32'(ovf_o), 32'd1);
            ha = res_a_o; hb = res_b_o;
        end else begin
            if (d)      chk(res_a_o == ea && res_b_o == eb, "R3 quotient/remainder", {res_b_o, res_a_o}, {eb, ea});
            else if (w) chk(res_a_o == ea && res_b_o == eb, "R2 word product", {res_b_o, res_a_o}, {eb, ea});
            else        chk(res_a_o == ea && res_b_o == eb, "R1 byte product", {res_b_o, res_a_o}, {eb, ea});
            chk(ovf_o == eo, "R7 overflow flag", 32'(ovf_o), 32'(eo));
            if (inject) chk(res_a_o == ea && res_b_o == eb, "R9 mid-run inputs ignored", {res_b_o, res_a_o}, {eb, ea});
            ha = 16'h0; hb = 16'h0;
        end
        chk(cy_o == 1'b0, "R8 carry cleared", 32'(cy_o), 32'd0);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R10 single pulse then idle", {30'h0, busy_o, done_o}, 32'd0);
        if (d && zero) begin
            for (int k = 0; k < 3; k++) @(negedge clk);
            chk(res_a_o == ha && res_b_o == hb, "R6 idle results stable", {res_b_o, res_a_o}, {hb, ha});
        end
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog act=%0d exp=%0d", WD_CYCLES, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0, "R11 reset control", {30'h0, busy_o, done_o}, 32'd0);
        chk(res_a_o == 0 && res_b_o == 0, "R11 reset results", {res_b_o, res_a_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Byte sweep, multiply and divide (R1, R3, R4, R5, R6, R7)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [15:0] a, b;
                a = 16'((i * 17) | ((i * 4099) << 8));
                b = 16'(((j * 17) ^ (j == 15 ? 0 : j)) & 255);
                if (j == 15) b = 16'hA5FF;
                run_op(1'b0, 1'b0, 1'(j & 1), 1'((i + j) & 1), a, b, (j == 3));
                run_op(1'b1, 1'b0, 1'(i & 1), 1'((i >> 1) & 1), a, b, (j == 5));
            end
        end
        // Word cases over every form and mode combination (R2, R3, R4, R5, R9)
        for (int k = 0; k < 24; k++) begin
            logic [15:0] a, b;
            a = 16'hFFFF ^ 16'(k * 4111);
            b = 16'(k * k * 331);
            for (int m = 0; m < 4; m++) begin
                run_op(1'b0, 1'b1, 1'(m & 1), 1'(m >> 1), a, b, (m == 2));
                run_op(1'b1, 1'b1, 1'(m & 1), 1'(m >> 1), a, b, (m == 1));
            end
        end
        run_op(1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op(1'b0, 1'b1, 1'b0, 1'b1, 16'd3, 16'd5, 1'b0);
        run_op(1'b1, 1'b1, 1'b0, 1'b0, 16'd7, 16'hFFFF, 1'b0);
        run_op(1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'd1, 1'b1);
        if (!ended) begin
            ended = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule